// File: doc/BRIEF.md
# Strobed Handshake Port

This block is the handshake engine for one 8-bit parallel port that runs in strobed mode. The peripheral and the processor exchange data through a latch, and three lines borrowed from the companion control port carry the flow control. In the input direction, the peripheral pulls an active-low strobe. The falling edge captures the pin data and raises an input-buffer-full flag. Once the strobe has gone high again, an interrupt request is raised if interrupts are enabled. A processor read of the port clears the flag.

In the output direction, a processor write loads the output latch and drives an active-low output-buffer-full line. The peripheral takes the byte and pulses an active-low acknowledge. The falling edge of the acknowledge releases the buffer-full line. The rising edge raises the interrupt when interrupts are enabled, and the next processor write clears that interrupt.

The interrupt enable is an internal flag with no pin of its own. It is written by the single-bit set/reset command of the control port, aimed at the bit index that the strobe or acknowledge pin occupies. A status word puts the flags in their control-port bit positions, with the enable shown where the strobe or acknowledge pin sits. Address decode and the control word are outside the block, which sees them as a direction input and one-cycle access pulses.

Top module: `hs_strobe_port`

## Requirements
- R1: After reset, in input direction the flag line is 0, in output direction it is 1, and the interrupt is 0 in both directions.
- R2: In input direction, a falling edge on the strobe pin latches pin data into the read data and sets the flag line to 1.
- R3: In input direction, a processor read pulse clears the flag line, and read data shows the latched byte.
- R4: In input direction, the interrupt is 1 exactly when the flag is 1, the enable is 1 and the strobe pin is high. It stays 0 while the strobe is held low.
- R5: A set/reset command with index 4 (input direction) or index 6 (output direction) loads the enable from its value bit. The default placement is the upper port. Commands to any other index leave the enable unchanged.
- R6: In output direction, a processor write puts the written byte on the data pins with the output enable at 1, and drives the flag line (buffer full, active low) to 0.
- R7: In output direction, a falling edge on the acknowledge pin returns the flag line to 1.
- R8: In output direction, a rising acknowledge edge while the flag line is 1 and the enable is 1 sets the interrupt. A processor write clears it.
- R9: The status word has the interrupt at bit 3. The flag is at bit 5 for input and bit 7 for output. The enable is at bit 4 for input and bit 6 for output. All other bits are 0.
- R10: In input direction, changes on the data pins while the strobe stays high do not alter the latched byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_in_i | input | 1 | 1 = input direction, 0 = output direction (from external control word) |
| cpu_rd_i | input | 1 | One-cycle processor read of the data port |
| cpu_wr_i | input | 1 | One-cycle processor write of the data port |
| cpu_wdata_i | input | 8 | Processor write data |
| cpu_rdata_o | output | 8 | Latched byte seen by the processor |
| bsr_we_i | input | 1 | One-cycle single-bit set/reset command on the control port |
| bsr_sel_i | input | 3 | Bit index of the command |
| bsr_val_i | input | 1 | Value of the command |
| hs_ctl_ni | input | 1 | Strobe (input direction) or acknowledge (output direction) pin, active low |
| pin_data_i | input | 8 | Data pins, inbound |
| pin_data_o | output | 8 | Data pins, outbound |
| pin_data_oe_o | output | 1 | Data pin output enable |
| hs_flag_o | output | 1 | Input-buffer-full, or active-low output-buffer-full |
| intr_o | output | 1 | Interrupt request |
| stat_o | output | 8 | Handshake status in control-port bit positions |

## Verification
The assertions assume that the direction input is static between resets. They also assume the strobe and acknowledge pins stay at each level for longer than the synchroniser depth, so that every pin edge reaches the edge detector. The stimulus changes direction only while reset is asserted. It holds each pin level for four clocks, and keeps the pin data stable across each strobe fall.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef struct packed {
    logic [2:0] intr_bit;
    logic [2:0] in_flag_bit;
    logic [2:0] in_ctl_bit;
    logic [2:0] out_flag_bit;
    logic [2:0] out_ctl_bit;
  } hs_pos_t;

  // Control-port bit placement for the upper (1) or lower (0) port.
  function automatic hs_pos_t pos_of(input bit upper);
    hs_pos_t p;
    if (upper) begin
      p.intr_bit     = 3'd3;
      p.in_flag_bit  = 3'd5;
      p.in_ctl_bit   = 3'd4;
      p.out_flag_bit = 3'd7;
      p.out_ctl_bit  = 3'd6;
    end else begin
      p.intr_bit     = 3'd0;
      p.in_flag_bit  = 3'd1;
      p.in_ctl_bit   = 3'd2;
      p.out_flag_bit = 3'd1;
      p.out_ctl_bit  = 3'd2;
    end
    return p;
  endfunction
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic lvl_o,
  output logic fall_o,
  output logic rise_o
);
  logic [STAGES-1:0] sq;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sq <= '1;
        else         sq <= pin_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sq <= '1;
        else         sq <= {sq[STAGES-2:0], pin_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= sq[STAGES-1];

  assign lvl_o  = sq[STAGES-1];
  assign fall_o = prev_q & ~sq[STAGES-1];
  assign rise_o = ~prev_q & sq[STAGES-1];
endmodule

// File: rtl/hs_in_path.sv
module hs_in_path #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              stb_fall_i,
  input  logic              stb_lvl_i,
  input  logic              rd_i,
  input  logic              inte_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ibf_o,
  output logic              intr_o
);
  logic [DATA_W-1:0] data_q;
  logic              ibf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      ibf_q  <= 1'b0;
    end else if (en_i) begin
      if (stb_fall_i) begin
        data_q <= data_i;
        ibf_q  <= 1'b1;       // a new byte wins over a same-cycle read
      end else if (rd_i) begin
        ibf_q  <= 1'b0;
      end
    end
  end

  assign data_o = data_q;
  assign ibf_o  = ibf_q;
  assign intr_o = en_i & ibf_q & inte_i & stb_lvl_i;
endmodule

// File: rtl/hs_out_path.sv
module hs_out_path #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ack_fall_i,
  input  logic              ack_rise_i,
  input  logic              inte_i,
  output logic [DATA_W-1:0] data_o,
  output logic              obf_no,
  output logic              intr_o
);
  logic [DATA_W-1:0] data_q;
  logic              obf_nq;
  logic              intr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      obf_nq <= 1'b1;
      intr_q <= 1'b0;
    end else if (en_i) begin
      if (wr_i) begin
        data_q <= wdata_i;
        obf_nq <= 1'b0;
        intr_q <= 1'b0;
      end else begin
        if (ack_fall_i) obf_nq <= 1'b1;
        if (ack_rise_i && obf_nq && inte_i) intr_q <= 1'b1;
      end
    end
  end

  assign data_o = data_q;
  assign obf_no = obf_nq;
  assign intr_o = intr_q;
endmodule

// File: rtl/hs_strobe_port.sv
module hs_strobe_port #(
  parameter int DATA_W      = 8,
  parameter int PC_W        = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit UPPER_PORT  = 1'b1,
  localparam int SEL_W      = $clog2(PC_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dir_in_i,
  input  logic              cpu_rd_i,
  input  logic              cpu_wr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  input  logic              bsr_we_i,
  input  logic [SEL_W-1:0]  bsr_sel_i,
  input  logic              bsr_val_i,
  input  logic              hs_ctl_ni,
  input  logic [DATA_W-1:0] pin_data_i,
  output logic [DATA_W-1:0] pin_data_o,
  output logic              pin_data_oe_o,
  output logic              hs_flag_o,
  output logic              intr_o,
  output logic [PC_W-1:0]   stat_o
);
  import hs_pkg::*;
  localparam hs_pos_t POS = pos_of(UPPER_PORT);

  logic              ctl_lvl, ctl_fall, ctl_rise;
  logic              inte_q;
  logic [SEL_W-1:0]  ctl_idx, flag_idx, intr_idx;
  logic [DATA_W-1:0] in_data, out_data;
  logic              in_ibf, in_intr, out_obf_n, out_intr;

  hs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (hs_ctl_ni),
    .lvl_o  (ctl_lvl),
    .fall_o (ctl_fall),
    .rise_o (ctl_rise)
  );

  assign ctl_idx  = SEL_W'(dir_in_i ? POS.in_ctl_bit  : POS.out_ctl_bit);
  assign flag_idx = SEL_W'(dir_in_i ? POS.in_flag_bit : POS.out_flag_bit);
  assign intr_idx = SEL_W'(POS.intr_bit);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                              inte_q <= 1'b0;
    else if (bsr_we_i && bsr_sel_i == ctl_idx) inte_q <= bsr_val_i;

  hs_in_path #(.DATA_W(DATA_W)) u_in (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (dir_in_i),
    .stb_fall_i (ctl_fall),
    .stb_lvl_i  (ctl_lvl),
    .rd_i       (cpu_rd_i),
    .inte_i     (inte_q),
    .data_i     (pin_data_i),
    .data_o     (in_data),
    .ibf_o      (in_ibf),
    .intr_o     (in_intr)
  );

  hs_out_path #(.DATA_W(DATA_W)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (~dir_in_i),
    .wr_i       (cpu_wr_i),
    .wdata_i    (cpu_wdata_i),
    .ack_fall_i (ctl_fall),
    .ack_rise_i (ctl_rise),
    .inte_i     (inte_q),
    .data_o     (out_data),
    .obf_no     (out_obf_n),
    .intr_o     (out_intr)
  );

  assign hs_flag_o     = dir_in_i ? in_ibf  : out_obf_n;
  assign intr_o        = dir_in_i ? in_intr : out_intr;
  assign cpu_rdata_o   = dir_in_i ? in_data : out_data;
  assign pin_data_o    = out_data;
  assign pin_data_oe_o = ~dir_in_i;

  always_comb begin
    stat_o           = '0;
    stat_o[intr_idx] = intr_o;
    stat_o[flag_idx] = hs_flag_o;
    stat_o[ctl_idx]  = inte_q;
  end
endmodule

// File: rtl/hs_strobe_port_chk.sv
module hs_strobe_port_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic dir_in_i,
  input logic cpu_rd_i,
  input logic cpu_wr_i,
  input logic ctl_lvl,
  input logic ctl_fall,
  input logic inte_q,
  input logic hs_flag_o,
  input logic intr_o
);
  p_ibf_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_in_i && ctl_fall |=> hs_flag_o);

  p_ibf_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_in_i && cpu_rd_i && !ctl_fall |=> !hs_flag_o);

  p_intr_strobe_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_in_i && !ctl_lvl |-> !intr_o);

  p_intr_needs_enable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intr_o |-> inte_q);

  p_write_fills_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dir_in_i && cpu_wr_i |=> !hs_flag_o && !intr_o);

  p_ack_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dir_in_i && ctl_fall && !cpu_wr_i |=> hs_flag_o);

  p_out_intr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dir_in_i && $rose(intr_o) |-> hs_flag_o && ctl_lvl);
endmodule

bind hs_strobe_port hs_strobe_port_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .dir_in_i  (dir_in_i),
  .cpu_rd_i  (cpu_rd_i),
  .cpu_wr_i  (cpu_wr_i),
  .ctl_lvl   (ctl_lvl),
  .ctl_fall  (ctl_fall),
  .inte_q    (inte_q),
  .hs_flag_o (hs_flag_o),
  .intr_o    (intr_o)
);

// File: tb/hs_strobe_port_tb_top.sv
`timescale 1ns/1ps
module hs_strobe_port_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       dir_in_i = 1'b1;
  logic       cpu_rd_i = 1'b0, cpu_wr_i = 1'b0;
  logic [7:0] cpu_wdata_i = '0, cpu_rdata_o;
  logic       bsr_we_i = 1'b0, bsr_val_i = 1'b0;
  logic [2:0] bsr_sel_i = '0;
  logic       hs_ctl_ni = 1'b1;
  logic [7:0] pin_data_i = '0, pin_data_o, stat_o;
  logic       pin_data_oe_o, hs_flag_o, intr_o;

  int total = 0;
  int bad   = 0;

  always #2.5 clk_i = ~clk_i;

  hs_strobe_port dut_i (.*);

  // vector: op[2:0] arg[7:0] exp_rd[7:0] exp_flag exp_intr exp_stat[7:0]
  localparam logic [2:0] OP_STB = 3'd0, OP_RD = 3'd1, OP_BSR = 3'd2;
  localparam int NV = 8;
  localparam logic [28:0] VEC [NV] = '{
    {OP_BSR, 8'h09, 8'h00, 1'b0, 1'b0, 8'h10},
    {OP_STB, 8'hA5, 8'h00, 1'b1, 1'b1, 8'h38},
    {OP_RD,  8'h00, 8'hA5, 1'b0, 1'b0, 8'h10},
    {OP_BSR, 8'h08, 8'h00, 1'b0, 1'b0, 8'h00},
    {OP_STB, 8'h3C, 8'h00, 1'b1, 1'b0, 8'h20},
    {OP_BSR, 8'h0D, 8'h00, 1'b1, 1'b0, 8'h20},
    {OP_BSR, 8'h09, 8'h00, 1'b1, 1'b1, 8'h38},
    {OP_RD,  8'h00, 8'h3C, 1'b0, 1'b0, 8'h10}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic do_reset(input logic dir);
    @(negedge clk_i);
    rst_ni = 1'b0;
    dir_in_i = dir;
    hs_ctl_ni = 1'b1;
    wait_n(2);
    rst_ni = 1'b1;
    wait_n(2);
  endtask

  task automatic strobe(input logic [7:0] d);
    pin_data_i = d;
    hs_ctl_ni = 1'b0;
    wait_n(4);
    hs_ctl_ni = 1'b1;
    wait_n(4);
  endtask

  task automatic bsr(input logic [2:0] sel, input logic val);
    bsr_we_i = 1'b1; bsr_sel_i = sel; bsr_val_i = val;
    wait_n(1);
    bsr_we_i = 1'b0;
    wait_n(1);
  endtask

  task automatic cpu_read(output logic [7:0] d);
    cpu_rd_i = 1'b1;
    d = cpu_rdata_o;
    wait_n(1);
    cpu_rd_i = 1'b0;
    wait_n(1);
  endtask

  task automatic cpu_write(input logic [7:0] d);
    cpu_wr_i = 1'b1; cpu_wdata_i = d;
    wait_n(1);
    cpu_wr_i = 1'b0;
    wait_n(1);
  endtask

  initial begin
    #500000;
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    // R1 reset, input direction
    do_reset(1'b1);
    chk("R1 flag in", {7'd0, hs_flag_o}, 8'h00);
    chk("R1 intr in", {7'd0, intr_o}, 8'h00);
    chk("R9 stat reset in", stat_o, 8'h00);

    for (int v = 0; v < NV; v++) begin
      logic [2:0] op;
      logic [7:0] arg, erd, est;
      logic ef, ei;
      {op, arg, erd, ef, ei, est} = VEC[v];
      case (op)
        OP_STB: strobe(arg);
        OP_RD: begin
          cpu_read(rd);
          chk("R3 read data", rd, erd);
        end
        default: bsr(arg[3:1], arg[0]);
      endcase
      chk(op == OP_STB ? "R2 flag" : op == OP_RD ? "R3 flag" : "R5 flag",
          {7'd0, hs_flag_o}, {7'd0, ef});
      chk("R4 intr", {7'd0, intr_o}, {7'd0, ei});
      chk("R9 stat", stat_o, est);
    end

    // R10: pins change with strobe high, latch holds
    strobe(8'h66);
    pin_data_i = 8'hFF;
    wait_n(4);
    cpu_read(rd);
    chk("R10 latch held", rd, 8'h66);

    // R4: strobe held low suppresses interrupt (enable is 1)
    pin_data_i = 8'h81;
    hs_ctl_ni = 1'b0;
    wait_n(4);
    chk("R2 flag during strobe", {7'd0, hs_flag_o}, 8'h01);
    chk("R4 intr held low", {7'd0, intr_o}, 8'h00);
    hs_ctl_ni = 1'b1;
    wait_n(4);
    chk("R4 intr after release", {7'd0, intr_o}, 8'h01);

    // Output direction
    do_reset(1'b0);
    chk("R1 flag out", {7'd0, hs_flag_o}, 8'h01);
    chk("R1 intr out", {7'd0, intr_o}, 8'h00);
    chk("R9 stat reset out", stat_o, 8'h80);
    bsr(3'd4, 1'b1);
    chk("R5 wrong index out", stat_o, 8'h80);
    bsr(3'd6, 1'b1);
    chk("R5 enable out", stat_o, 8'hC0);
    cpu_write(8'h5A);
    chk("R6 pin data", pin_data_o, 8'h5A);
    chk("R6 oe", {7'd0, pin_data_oe_o}, 8'h01);
    chk("R6 flag low", {7'd0, hs_flag_o}, 8'h00);
    chk("R9 stat full", stat_o, 8'h40);
    hs_ctl_ni = 1'b0;
    wait_n(4);
    chk("R7 flag released", {7'd0, hs_flag_o}, 8'h01);
    chk("R8 intr before rise", {7'd0, intr_o}, 8'h00);
    hs_ctl_ni = 1'b1;
    wait_n(4);
    chk("R8 intr set", {7'd0, intr_o}, 8'h01);
    chk("R9 stat intr", stat_o, 8'hC8);
    cpu_write(8'h11);
    chk("R8 intr cleared", {7'd0, intr_o}, 8'h00);
    chk("R6 second byte", pin_data_o, 8'h11);
    // R8: no interrupt with enable cleared
    bsr(3'd6, 1'b0);
    hs_ctl_ni = 1'b0;
    wait_n(4);
    hs_ctl_ni = 1'b1;
    wait_n(4);
    chk("R8 no intr disabled", {7'd0, intr_o}, 8'h00);
    chk("R7 flag after ack", {7'd0, hs_flag_o}, 8'h01);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule